// File: doc/BRIEF.md
# Packed-Symbol Error Corrector

This block sits behind a Reed-Solomon decoder that works on 12-bit symbols packed tightly into a byte-wide page buffer. The buffer holds a 2048-byte data area followed by a 64-byte spare area. The spare area begins with the 14 check bytes. The decoder supplies a list of error positions, each with a 12-bit error value. The block first checks every entry. If all of them can be applied, it folds each value into the one or two bytes that the symbol covers. Each byte is updated by a read-modify-write on a single-port buffer.

Symbol `p` covers twelve consecutive bits of the byte stream, read most-significant bit first. Those bits start at stream bit `12p - 4`. So odd symbols begin on a byte boundary and even symbols begin halfway through a byte. Symbol 0 has only its low 8 bits on the page. The byte address counts across both areas: data byte `i` is at address `i`, and spare byte `k` is at address `2048 + k`. As a result, one symbol crosses from the last data byte into the first spare byte.

A job starts with a pulse that carries the number of pairs to expect. The pairs then arrive one per cycle, and the block finishes with a single-cycle done pulse that carries either a count of corrected symbols or a failure flag.

Top module: `rs_symbol_fixer`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: `start` is accepted only while `busy` is low. After a start with a count from 1 to 4, one pair is taken on each cycle that `pair_valid` is high. `pair_valid` has no effect while the block is idle.
- R3: An odd position `p` from 1 to 1373 XORs `pat[11:4]` into address `3p/2` (integer division) and `{pat[3:0],4'b0}` into address `3p/2+1`.
- R4: An even nonzero position `p` up to 1374 XORs `{4'b0,pat[11:8]}` into address `3p/2-1` and `pat[7:0]` into address `3p/2`.
- R5: Position 0 XORs `pat[7:0]` into address 0 only. If `pat[11:8]` is nonzero, the whole job fails.
- R6: Spare byte `k` is at address `2048+k`. Position 1365 splits across addresses 2047 and 2048. No position up to 1374 touches an address at or above 2062, which is past the 14 check bytes.
- R7: Any position above 1374 makes the job fail.
- R8: A failing job writes nothing to the buffer. It ends with `done_fail` set and `done_fixed` equal to 0.
- R9: A start count of 0 ends at once with success and a count of 0. A start count above 4 ends at once with failure. In both cases no pairs are taken.
- R10: `done` is a single-cycle pulse. On success, `done_fixed` equals the number of pairs, and every pair is applied in order, including repeated positions.
- R11: Each byte update raises `mem_rd` for one cycle and, in the next cycle, `mem_wr` at the same address with `mem_rdata` XOR the mask. The read data arrives one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (taken when idle) |
| start_cnt | input | 3 | Number of pairs that follow |
| pair_valid | input | 1 | A position/value pair is present |
| pair_pos | input | 11 | Symbol position |
| pair_pat | input | 12 | 12-bit error value |
| busy | output | 1 | A job is in progress |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 12 | Buffer byte address |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Buffer read data, one cycle after `mem_rd` |
| done | output | 1 | Job finished (one cycle) |
| done_fixed | output | 3 | Symbols corrected, valid with `done` |
| done_fail | output | 1 | Job was uncorrectable, valid with `done` |

## Verification
The bench builds the block with its default parameters: a 2048-byte data area, a 64-byte spare area, 14 check bytes and up to four pairs. With these values every real position from 0 to 1374 can be reached, including the data-to-spare crossing at 1365, the last check byte at 1374, and the first illegal position, 1375. The bench works out expected buffer contents from the bit-stream view of symbol placement, not from the byte rules above. It compares the whole 2112-byte buffer after every job.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;

  localparam int BA_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COLLECT,
    S_APPLY,
    S_DONE
  } fix_state_t;

  typedef struct packed {
    logic [BA_W-1:0] a0;
    logic [7:0]      m0;
    logic [BA_W-1:0] a1;
    logic [7:0]      m1;
    logic            two;
  } touch_t;

  // Byte addresses and XOR masks touched by one 12-bit symbol.
  function automatic touch_t map_sym(input logic [BA_W-1:0] pos,
                                     input logic [11:0] pat);
    touch_t t;
    logic [BA_W:0] triple;
    logic [BA_W-1:0] half;
    triple = (BA_W+1)'(pos) * (BA_W+1)'(3);
    half   = triple[BA_W:1];
    t = '0;
    if (pos == '0) begin
      t.a0  = '0;
      t.m0  = pat[7:0];
      t.two = 1'b0;
    end else if (pos[0]) begin
      t.a0  = half;
      t.m0  = pat[11:4];
      t.a1  = half + 1'b1;
      t.m1  = {pat[3:0], 4'h0};
      t.two = 1'b1;
    end else begin
      t.a0  = half - 1'b1;
      t.m0  = {4'h0, pat[11:8]};
      t.a1  = half;
      t.m1  = pat[7:0];
      t.two = 1'b1;
    end
    return t;
  endfunction

  // A pair that cannot be applied to the page.
  function automatic logic sym_bad(input logic [BA_W-1:0] pos,
                                   input logic [11:0] pat,
                                   input int unsigned last_pos);
    return (32'(pos) > last_pos) || (pos == '0 && pat[11:8] != 4'h0);
  endfunction

endpackage

// File: rtl/rsfix_collect.sv
module rsfix_collect #(
  parameter int MAX_ERR = 4,
  parameter int POS_W   = 11,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap,
  input  logic [POS_W-1:0] in_pos,
  input  logic [11:0]      in_pat,
  input  logic             in_bad,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [POS_W-1:0] out_pos,
  output logic [11:0]      out_pat,
  output logic [CNT_W-1:0] n_got,
  output logic             bad_seen
);

  logic [POS_W-1:0] slot_pos [MAX_ERR];
  logic [11:0]      slot_pat [MAX_ERR];

  for (genvar i = 0; i < MAX_ERR; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_pos[i] <= '0;
        slot_pat[i] <= '0;
      end else if (cap && n_got == CNT_W'(i)) begin
        slot_pos[i] <= in_pos;
        slot_pat[i] <= in_pat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_got    <= '0;
      bad_seen <= 1'b0;
    end else if (clr) begin
      n_got    <= '0;
      bad_seen <= 1'b0;
    end else if (cap) begin
      n_got    <= n_got + 1'b1;
      bad_seen <= bad_seen | in_bad;
    end
  end

  always_comb begin
    out_pos = '0;
    out_pat = '0;
    for (int i = 0; i < MAX_ERR; i++) begin
      if (rd_idx == CNT_W'(i)) begin
        out_pos = slot_pos[i];
        out_pat = slot_pat[i];
      end
    end
  end

  // R2: never more captures than slots
  a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (n_got < CNT_W'(MAX_ERR)));

endmodule

// File: rtl/rsfix_rmw.sv
module rsfix_rmw #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mask,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              byte_done
);

  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase <= 1'b0;
    else if (phase)     phase <= 1'b0;
    else if (go)        phase <= 1'b1;
  end

  assign mem_rd    = go && !phase;
  assign mem_wr    = phase;
  assign mem_addr  = addr;
  assign mem_wdata = mem_rdata ^ mask;
  assign byte_done = phase;

  // R11: a write always follows a read of the same byte
  a_r11_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));

  // R11: a read is never repeated without its write
  a_r11_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

endmodule

// File: rtl/rs_symbol_fixer.sv
module rs_symbol_fixer #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ECC_BYTES   = 14,
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 11,
  localparam int ADDR_W     = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              pair_valid,
  input  logic [POS_W-1:0]  pair_pos,
  input  logic [11:0]       pair_pat,
  output logic              busy,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [CNT_W-1:0]  done_fixed,
  output logic              done_fail
);

  import rsfix_pkg::*;

  localparam int unsigned LAST_POS = ((DATA_BYTES + ECC_BYTES) * 8 + 4) / 12 - 1;
  localparam int unsigned PAGE_END = DATA_BYTES + ECC_BYTES;

  fix_state_t       state;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] idx;
  logic             second;
  logic             res_fail;
  logic [CNT_W-1:0] res_fixed;
  logic             wr_seen;

  // named internal events
  logic             take_start;
  logic             take_pair;
  logic             last_pair;
  logic             pair_bad;
  logic             job_bad;
  logic             byte_done;
  logic             slot_last;

  logic [POS_W-1:0] slot_pos;
  logic [11:0]      slot_pat;
  logic [CNT_W-1:0] n_got;
  logic             bad_seen;
  touch_t           cur;
  logic [ADDR_W-1:0] sel_addr;
  logic [7:0]       sel_mask;

  function automatic logic [BA_W-1:0] ext_pos(input logic [POS_W-1:0] p);
    return BA_W'(p);
  endfunction

  assign take_start = (state == S_IDLE) && start;
  assign take_pair  = (state == S_COLLECT) && pair_valid;
  assign last_pair  = take_pair && (n_got == need - 1'b1);
  assign pair_bad   = sym_bad(ext_pos(pair_pos), pair_pat, LAST_POS);
  assign job_bad    = bad_seen || pair_bad;

  rsfix_collect #(
    .MAX_ERR (MAX_ERR),
    .POS_W   (POS_W),
    .CNT_W   (CNT_W)
  ) i_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (take_start),
    .cap      (take_pair),
    .in_pos   (pair_pos),
    .in_pat   (pair_pat),
    .in_bad   (pair_bad),
    .rd_idx   (idx),
    .out_pos  (slot_pos),
    .out_pat  (slot_pat),
    .n_got    (n_got),
    .bad_seen (bad_seen)
  );

  assign cur       = map_sym(ext_pos(slot_pos), slot_pat);
  assign sel_addr  = second ? cur.a1[ADDR_W-1:0] : cur.a0[ADDR_W-1:0];
  assign sel_mask  = second ? cur.m1 : cur.m0;
  assign slot_last = (idx == need - 1'b1) && (second || !cur.two);

  rsfix_rmw #(
    .ADDR_W (ADDR_W)
  ) i_rmw (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (state == S_APPLY),
    .addr      (sel_addr),
    .mask      (sel_mask),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .byte_done (byte_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      need      <= '0;
      idx       <= '0;
      second    <= 1'b0;
      res_fail  <= 1'b0;
      res_fixed <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take_start) begin
            need   <= start_cnt;
            idx    <= '0;
            second <= 1'b0;
            if (start_cnt == '0) begin
              res_fail  <= 1'b0;
              res_fixed <= '0;
              state     <= S_DONE;
            end else if (start_cnt > CNT_W'(MAX_ERR)) begin
              res_fail  <= 1'b1;
              res_fixed <= '0;
              state     <= S_DONE;
            end else begin
              state <= S_COLLECT;
            end
          end
        end
        S_COLLECT: begin
          if (last_pair) begin
            if (job_bad) begin
              res_fail  <= 1'b1;
              res_fixed <= '0;
              state     <= S_DONE;
            end else begin
              state <= S_APPLY;
            end
          end
        end
        S_APPLY: begin
          if (byte_done) begin
            if (slot_last) begin
              res_fail  <= 1'b0;
              res_fixed <= need;
              state     <= S_DONE;
            end else if (!second && cur.two) begin
              second <= 1'b1;
            end else begin
              second <= 1'b0;
              idx    <= idx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wr_seen <= 1'b0;
    else if (state == S_IDLE)  wr_seen <= 1'b0;
    else if (mem_wr)           wr_seen <= 1'b1;
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign done_fixed = done ? res_fixed : '0;
  assign done_fail  = done && res_fail;

  // R1: idle outputs quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !done));

  // R6: every access lands inside data plus check bytes
  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (32'(mem_addr) < PAGE_END));

  // R8: a failed job never wrote the buffer
  a_r8_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fail) |-> (!wr_seen && done_fixed == '0));

  // R10: done lasts one cycle and reports a bounded count
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_fixed <= CNT_W'(MAX_ERR)));

endmodule

// File: tb/test_rs_symbol_fixer.sv
module test_rs_symbol_fixer;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 2112;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  start_cnt = '0;
  logic        pair_valid = 1'b0;
  logic [10:0] pair_pos = '0;
  logic [11:0] pair_pat = '0;
  logic        busy, mem_rd, mem_wr, done, done_fail;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [2:0]  done_fixed;

  logic [7:0] mem     [NBYTES];
  logic [7:0] exp_mem [NBYTES];

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int proto_err = 0;
  logic prev_rd = 1'b0;
  logic [11:0] prev_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_symbol_fixer i_rs_symbol_fixer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_cnt  (start_cnt),
    .pair_valid (pair_valid),
    .pair_pos   (pair_pos),
    .pair_pat   (pair_pat),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .done_fixed (done_fixed),
    .done_fail  (done_fail)
  );

  // buffer model: read data one cycle after the strobe
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // protocol monitor for R11
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr && !(prev_rd && prev_addr == mem_addr)) proto_err++;
      if ((mem_rd || mem_wr) && mem_addr >= 12'd2062) proto_err++;
      prev_rd   <= mem_rd;
      prev_addr <= mem_addr;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < NBYTES; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
  endtask

  // Expected image from the bit-stream view: symbol p spans stream bits
  // 12p-4 .. 12p+7, most significant bit first within every byte.
  task automatic ref_apply(input int p, input int pat);
    for (int i = 0; i < 12; i++) begin
      int bitpos;
      bitpos = 12 * p - 4 + i;
      if (bitpos >= 0 && ((pat >> (11 - i)) & 1) == 1)
        exp_mem[bitpos / 8] = exp_mem[bitpos / 8] ^ 8'(1 << (7 - bitpos % 8));
    end
  endtask

  function automatic bit ref_bad(input int p, input int pat);
    return (p > 1374) || (p == 0 && pat > 255);
  endfunction

  task automatic cmp_mem(input string req);
    int bad;
    int first;
    bad = 0;
    first = -1;
    for (int i = 0; i < NBYTES; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (bad != 0)
      $display("  first mismatch at byte %0d: actual %0h expected %0h",
               first, mem[first], exp_mem[first]);
    chk(req, "buffer mismatching bytes", bad, 0);
  endtask

  task automatic run_job(input string req, input int n, input int ps[4], input int pt[4]);
    bit exp_fail;
    int npairs;
    int sent;
    bit got;
    int g_fixed;
    int g_fail;
    exp_fail = (n > 4);
    npairs = (n > 4) ? 0 : n;
    for (int i = 0; i < npairs; i++) if (ref_bad(ps[i], pt[i])) exp_fail = 1;
    if (!exp_fail) for (int i = 0; i < npairs; i++) ref_apply(ps[i], pt[i]);
    @(negedge clk);
    start = 1'b1;
    start_cnt = 3'(n);
    sent = 0;
    got = 0;
    g_fixed = -1;
    g_fail = -1;
    for (int c = 0; c < 200 && !got; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        got = 1;
        g_fixed = int'(done_fixed);
        g_fail = int'(done_fail);
      end
      if (sent < npairs) begin
        pair_valid = 1'b1;
        pair_pos = 11'(ps[sent]);
        pair_pat = 12'(pt[sent]);
        sent++;
      end else begin
        pair_valid = 1'b0;
      end
    end
    pair_valid = 1'b0;
    chk(req, "done seen", int'(got), 1);
    chk(req, "fail flag", g_fail, int'(exp_fail));
    chk(req, "fixed count", g_fixed, exp_fail ? 0 : n);
    @(negedge clk);
    cmp_mem(req);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "strobes", int'(mem_rd | mem_wr), 0);
  endtask

  task automatic t_idle_ignore();
    int ps[4] = '{0, 0, 0, 0};
    int pt[4] = '{0, 0, 0, 0};
    @(negedge clk);
    pair_valid = 1'b1;
    pair_pos = 11'd3;
    pair_pat = 12'hFFF;
    @(negedge clk);
    chk("R2", "busy after idle pair", int'(busy), 0);
    chk("R2", "strobes after idle pair", int'(mem_rd | mem_wr), 0);
    pair_valid = 1'b0;
    run_job("R9", 0, ps, pt);
  endtask

  task automatic t_odd();
    int ps[4] = '{7, 0, 0, 0};
    int pt[4] = '{12'hABC, 0, 0, 0};
    run_job("R3", 1, ps, pt);
  endtask

  task automatic t_even();
    int ps[4] = '{8, 0, 0, 0};
    int pt[4] = '{12'h5A3, 0, 0, 0};
    run_job("R4", 1, ps, pt);
  endtask

  task automatic t_pos0();
    int ps[4] = '{0, 0, 0, 0};
    int pt[4] = '{12'h05C, 0, 0, 0};
    run_job("R5", 1, ps, pt);
    pt[0] = 12'h15C;
    run_job("R5", 1, ps, pt);
  endtask

  task automatic t_spare();
    int ps[4] = '{1365, 1374, 1373, 1366};
    int pt[4] = '{12'h9E7, 12'hFFF, 12'h3C5, 12'h801};
    run_job("R6", 4, ps, pt);
  endtask

  task automatic t_out_of_range();
    int ps[4] = '{10, 1375, 20, 0};
    int pt[4] = '{12'h111, 12'h222, 12'h333, 0};
    run_job("R7", 3, ps, pt);
  endtask

  task automatic t_bad_last();
    int ps[4] = '{2, 3, 4, 0};
    int pt[4] = '{12'h0F0, 12'hF0F, 12'h777, 12'h100};
    run_job("R8", 4, ps, pt);
  endtask

  task automatic t_too_many();
    int ps[4] = '{0, 0, 0, 0};
    int pt[4] = '{0, 0, 0, 0};
    run_job("R9", 5, ps, pt);
  endtask

  task automatic t_mixed();
    int ps[4] = '{2, 3, 900, 1366};
    int pt[4] = '{12'hC3A, 12'h5E1, 12'hFFF, 12'h00F};
    run_job("R10", 4, ps, pt);
  endtask

  task automatic t_duplicate();
    int ps[4] = '{5, 5, 0, 0};
    int pt[4] = '{12'h4B6, 12'h4B6, 0, 0};
    run_job("R10", 2, ps, pt);
  endtask

  initial begin
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_odd();
    t_even();
    t_pos0();
    t_spare();
    t_out_of_range();
    t_bad_last();
    t_too_many();
    t_mixed();
    t_duplicate();
    chk("R11", "read-modify-write protocol errors", proto_err, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule